// File: doc/BRIEF.md
# Auto-Incrementing Sequential Read Port

This block lets a processor stream bulk data, such as speech samples or lookup tables, out of a large memory through one fixed data location. The processor writes a 16-bit start address to a load location. After that, each read of the data location returns the word at the current address. The pointer then moves forward by one, so the processor never sends a per-word address after the initial load.

The processor decodes its own address space and drives two select inputs into the block: a load select and a read select. The pointer is built from cascaded 4-bit counter stages. The carry passes through the stage enables. The memory chip-enable and output-enable are driven only while a data read is in progress. The bulk memory shares the processor data bus with a program RAM, so the block also drives a disable to that RAM for the whole read. The pointer advances when the read strobe ends, which leaves the address steady for the full strobe. A read, one idle cycle and a second read therefore see consecutive words.

Top module: `seq_read_port`

## Requirements
- R1: While reset is asserted, and until it has been released through two clock edges, the address output is 0x0000, both memory enables are high (inactive), the program-RAM disable is low and the read data output is 0x0000.
- R2: A clock edge with `ld_sel` high loads `wdata` into the pointer, and `mem_addr` shows it from the next cycle.
- R3: While `rd_sel` is high, `mem_ce_n` and `mem_oe_n` are low and `rd_data` equals `mem_rdata` for the current `mem_addr`. While `rd_sel` is low, both enables are high and `rd_data` is 0x0000.
- R4: The pointer increments by one on the first clock edge that sees `rd_sel` low after a strobe, so `mem_addr` is old+1 one cycle after the strobe drops.
- R5: A read strobe held high for several cycles leaves `mem_addr` stable for its whole length and causes exactly one increment.
- R6: `pram_dis` is high on every cycle `rd_sel` is high and low otherwise. A load alone activates neither memory enable nor `pram_dis`.
- R7: Incrementing from 0xFFFF gives 0x0000, with no other indication.
- R8: A load takes priority over a read. If `ld_sel` is high during a strobe, or on the edge where the trailing edge is seen, the pointer takes `wdata` and that read causes no increment.
- R9: The carry passes correctly across every 4-bit stage boundary, for example 0x0FFF to 0x1000 and 0x00FF to 0x0100.
- R10: With no load and no trailing strobe edge, the pointer holds its value.
- R11: Two one-cycle reads separated by one idle cycle return the words at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_sel | input | 1 | Decoded write select for the start-address location |
| rd_sel | input | 1 | Decoded read strobe for the data location |
| wdata | input | 16 | Processor write data (start address) |
| mem_rdata | input | 16 | Data returned by the bulk memory |
| mem_addr | output | 16 | Current pointer driven to the bulk memory |
| mem_ce_n | output | 1 | Bulk memory chip enable, active low |
| mem_oe_n | output | 1 | Bulk memory output enable, active low |
| pram_dis | output | 1 | Holds the shared program RAM off the data bus |
| rd_data | output | 16 | Word presented to the processor during a read |

## Verification
The bench targets the trailing-edge timing in two cases. A design that advanced on the leading edge would return the word after the wanted one. A design that advanced on every high cycle of a long strobe would skip words. It drives carries through each 4-bit stage and the 0xFFFF wrap; a broken stage enable shows up as a jump of 16 or 256. It sets a load against an active strobe and against the cycle that retires a strobe. A design without load priority would land on the loaded value plus one. It also checks that the program-RAM disable tracks the strobe exactly, since any gap there means bus contention.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;
  localparam int unsigned SEQ_ADDR_W  = 16;
  localparam int unsigned SEQ_DATA_W  = 16;
  localparam int unsigned SEQ_STAGE_W = 4;
endpackage

// File: rtl/seqrd_strobe.sv
module seqrd_strobe (
  input  logic clk,
  input  logic rst_ok_n,
  input  logic ld_sel,
  input  logic rd_sel,
  output logic inc_en
);
  logic armed_q, armed_d;
  logic cancel_q, cancel_d;

  always_comb begin
    cancel_d = rd_sel & (ld_sel | cancel_q);
    armed_d  = rd_sel & ~ld_sel & ~cancel_q;
    inc_en   = armed_q & ~rd_sel & ~ld_sel;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      cancel_q <= cancel_d;
    end
  end

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ld_sel && rd_sel) |=> !inc_en);
endmodule

// File: rtl/seqrd_counter.sv
module seqrd_counter #(
  parameter int unsigned ADDR_W  = seqrd_pkg::SEQ_ADDR_W,
  parameter int unsigned STAGE_W = seqrd_pkg::SEQ_STAGE_W
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] q
);
  localparam int unsigned NSTAGE = ADDR_W / STAGE_W;

  logic [NSTAGE:0]     stage_en;
  logic [ADDR_W-1:0]   q_d;

  assign stage_en[0] = inc_en;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [STAGE_W-1:0] nib_q;
    logic [STAGE_W-1:0] nib_d;
    assign nib_q = q[s*STAGE_W +: STAGE_W];
    assign stage_en[s+1] = stage_en[s] & (&nib_q);
    always_comb begin
      if (load)
        nib_d = load_val[s*STAGE_W +: STAGE_W];
      else if (stage_en[s])
        nib_d = nib_q + 1'b1;
      else
        nib_d = nib_q;
    end
    assign q_d[s*STAGE_W +: STAGE_W] = nib_d;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) q <= '0;
    else           q <= q_d;
  end

  // R4
  inc_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (inc_en && !load) |=> (q == $past(q) + 1'b1));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (inc_en && !load && (&q)) |=> (q == '0));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!inc_en && !load) |=> $stable(q));
endmodule

// File: rtl/seqrd_enables.sv
module seqrd_enables #(
  parameter int unsigned DATA_W = seqrd_pkg::SEQ_DATA_W
) (
  input  logic              rst_ok_n,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              pram_dis,
  output logic [DATA_W-1:0] rd_data
);
  logic rd_act;

  always_comb begin
    rd_act   = rd_sel & rst_ok_n;
    mem_ce_n = ~rd_act;
    mem_oe_n = ~rd_act;
    pram_dis = rd_act;
    rd_data  = rd_act ? mem_rdata : '0;
  end
endmodule

// File: rtl/seq_read_port.sv
module seq_read_port #(
  parameter int unsigned ADDR_W  = seqrd_pkg::SEQ_ADDR_W,
  parameter int unsigned DATA_W  = seqrd_pkg::SEQ_DATA_W,
  parameter int unsigned STAGE_W = seqrd_pkg::SEQ_STAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              pram_dis,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;
  logic       inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  seqrd_strobe u_strobe (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .ld_sel   (ld_sel),
    .rd_sel   (rd_sel),
    .inc_en   (inc_en)
  );

  seqrd_counter #(.ADDR_W(ADDR_W), .STAGE_W(STAGE_W)) u_cnt (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .load     (ld_sel),
    .load_val (wdata[ADDR_W-1:0]),
    .inc_en   (inc_en),
    .q        (mem_addr)
  );

  seqrd_enables #(.DATA_W(DATA_W)) u_en (
    .rst_ok_n  (rst_ok_n),
    .rd_sel    (rd_sel),
    .mem_rdata (mem_rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .pram_dis  (pram_dis),
    .rd_data   (rd_data)
  );

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ld_sel |=> (mem_addr == $past(wdata[ADDR_W-1:0])));
  // R5
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rd_sel && $past(rd_sel) && !$past(ld_sel)) |-> $stable(mem_addr));
  // R6
  pram_guard_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!mem_oe_n || !mem_ce_n) |-> pram_dis);
endmodule

// File: tb/sim_seq_read_port.sv
module sim_seq_read_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_sel, rd_sel;
  logic [15:0] wdata, mem_rdata, mem_addr, rd_data;
  logic        mem_ce_n, mem_oe_n, pram_dis;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  assign mem_rdata = memf(mem_addr);

  seq_read_port u0 (
    .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .rd_sel(rd_sel),
    .wdata(wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .pram_dis(pram_dis),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk); ld_sel = 1'b1; wdata = v;
    #1 chk("R6 load-no-enable", {mem_ce_n, mem_oe_n, pram_dis}, 3'b110);
    @(negedge clk); ld_sel = 1'b0;
    #1 chk("R2 load", mem_addr, v);
  endtask

  task automatic do_read(input logic [15:0] ea);
    @(negedge clk); rd_sel = 1'b1;
    #1 chk("R3 addr", mem_addr, ea);
    chk("R3 data", rd_data, memf(ea));
    chk("R3/R6 enables", {mem_ce_n, mem_oe_n, pram_dis}, 3'b001);
    @(negedge clk); rd_sel = 1'b0;
    #1 chk("R3 idle", {mem_ce_n, mem_oe_n, pram_dis, rd_data}, {3'b110, 16'h0});
  endtask

  // {is_load, load value, expected address}
  localparam logic [32:0] VEC [0:13] = '{
    {1'b1, 16'h1234, 16'h1234},
    {1'b0, 16'h0000, 16'h1234},
    {1'b0, 16'h0000, 16'h1235},
    {1'b0, 16'h0000, 16'h1236},
    {1'b1, 16'h0FFE, 16'h0FFE},
    {1'b0, 16'h0000, 16'h0FFE},
    {1'b0, 16'h0000, 16'h0FFF},
    {1'b0, 16'h0000, 16'h1000},
    {1'b1, 16'h00FF, 16'h00FF},
    {1'b0, 16'h0000, 16'h00FF},
    {1'b0, 16'h0000, 16'h0100},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0000, 16'hFFFF},
    {1'b0, 16'h0000, 16'h0000}
  };

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_sel = 1'b0; rd_sel = 1'b0; wdata = '0;
    #1 rd_sel = 1'b1;
    #1 chk("R1 reset outs", {mem_addr, mem_ce_n, mem_oe_n, pram_dis, rd_data},
           {16'h0, 3'b110, 16'h0});
    rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1 after release", mem_addr, 16'h0);

    // R2 R3 R4 R7 R9 R11: table of loads and back-to-back reads
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][32]) do_load(VEC[i][31:16]);
      else            do_read(VEC[i][15:0]);
    end
    @(negedge clk); #1 chk("R7 wrap", mem_addr, 16'h0001);

    // R10 idle hold
    repeat (5) @(negedge clk);
    #1 chk("R10 hold", mem_addr, 16'h0001);

    // R5 long strobe
    do_load(16'h4000);
    @(negedge clk); rd_sel = 1'b1;
    repeat (3) begin
      @(negedge clk); #1 chk("R5 stable", mem_addr, 16'h4000);
      chk("R5 data", rd_data, memf(16'h4000));
    end
    rd_sel = 1'b0;
    @(negedge clk); #1 chk("R5 single inc", mem_addr, 16'h4001);
    @(negedge clk); #1 chk("R5 no extra", mem_addr, 16'h4001);

    // R8 load during strobe
    @(negedge clk); rd_sel = 1'b1;
    @(negedge clk); ld_sel = 1'b1; wdata = 16'h7770;
    @(negedge clk); ld_sel = 1'b0; rd_sel = 1'b0;
    #1 chk("R8 load in strobe", mem_addr, 16'h7770);
    @(negedge clk); #1 chk("R8 no inc", mem_addr, 16'h7770);
    @(negedge clk); #1 chk("R8 still", mem_addr, 16'h7770);

    // R8 load on trailing-edge cycle
    @(negedge clk); rd_sel = 1'b1;
    @(negedge clk); rd_sel = 1'b0; ld_sel = 1'b1; wdata = 16'h2220;
    @(negedge clk); ld_sel = 1'b0;
    #1 chk("R8 load at trail", mem_addr, 16'h2220);
    @(negedge clk); #1 chk("R8 trail no inc", mem_addr, 16'h2220);

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0; rd_sel = 1'b1;
    #1 chk("R1 mid reset", {mem_addr, mem_ce_n, mem_oe_n, pram_dis},
           {16'h0, 3'b110});
    rd_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(16'h0000);
    @(negedge clk); #1 chk("R4 after reset", mem_addr, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule